// File: doc/BRIEF.md
# Asynchronous External Memory Write Sequencer

This block turns a single-word write request into the strobe sequence that an asynchronous external memory expects. A request carries an address and a data word. The block accepts it over a valid/ready handshake. It then drives the address and an active-low chip select. After a fixed one-cycle setup it pulls an active-low write strobe down, with the data driver enabled. It keeps the strobe low for a programmed number of wait cycles and keeps address, select and data valid for a programmed number of hold cycles after the strobe rises. Finally it waits out a recovery gap before it accepts the next request.

A configuration word gives the wait count (5 bits), the hold count (3 bits) and an acknowledge-enable bit. All three are captured when a request is accepted. When acknowledge is enabled, an external ready-style input stretches the strobe. The input is brought through a two-stage synchronizer, and the strobe is released only once the wait count has run out and the synchronized acknowledge is high. When acknowledge is disabled, only the wait count sets the timing.

Top module: `asyw_write_seq`

## Requirements
- R1: After reset, req_ready is 1, mem_sel_n is 1, mem_wr_n is 1 and mem_data_oe is 0.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the sequence is back in idle, which is cfg-dependent: L+H+3 edges after acceptance, where L is the strobe length and H the hold count.
- R3: For exactly one cycle after acceptance, mem_sel_n is 0 and mem_wr_n is 1. The strobe falls on the following edge.
- R4: With acknowledge disabled or held high, mem_wr_n stays 0 for max(W,1) cycles, where W is the captured wait count.
- R5: After mem_wr_n rises, mem_sel_n stays 0 and mem_data_oe stays 1 for H cycles. With H = 0, both are released on the same edge as the strobe rises.
- R6: mem_data_oe is 1 only while the strobe is low or in the hold phase. It never becomes 1 while mem_wr_n is 1.
- R7: With cfg_ack_en = 1, the strobe is held low while the synchronized acknowledge is 0. If mem_ack rises between edges E-1 and E after the wait count has run out, mem_wr_n rises on edge E+2. With cfg_ack_en = 0, mem_ack has no effect on the strobe length.
- R8: After the hold phase, two recovery cycles follow with mem_sel_n = 1, mem_wr_n = 1 and req_ready = 0. A new strobe never falls less than two cycles after the previous one rose.
- R9: Changes to cfg_wait, cfg_hold and cfg_ack_en after acceptance do not change the running access.
- R10: mem_addr and mem_data_out hold the values captured at acceptance for as long as mem_sel_n is 0, whatever req_addr and req_data do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| cfg_wait | input | WAIT_W | Wait-cycle count for the strobe |
| cfg_hold | input | HOLD_W | Hold-cycle count after the strobe |
| cfg_ack_en | input | 1 | 1: acknowledge stretches the strobe |
| mem_ack | input | 1 | Asynchronous acknowledge from the memory side |
| mem_addr | output | ADDR_W | Address to memory |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_data_out | output | DATA_W | Data to the bus driver |
| mem_data_oe | output | 1 | Data bus driver enable |

## Verification
The assertions assume a few things about the inputs. reset is applied before the first request. mem_ack is free to change at any time, because it only reaches the control logic through the synchronizer. The configuration inputs matter only on the accepting edge. The stimulus drives every input at the falling clock edge. It lowers the acknowledge at least three cycles before a stretched access, so that the synchronizer output is settled low when the strobe begins. It also scrambles the configuration and request fields straight after acceptance, which exercises the capture rules without breaking the assumptions above.

// File: rtl/asyw_pkg.sv
package asyw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_STROBE  = 3'd2,
        ST_HOLD    = 3'd3,
        ST_RECOVER = 3'd4
    } asyw_state_e;

endpackage

// File: rtl/asyw_sync.sv
module asyw_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = din;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/asyw_cnt.sv
module asyw_cnt #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                      cnt_d = load_val;
        else if (dec && cnt_q != '0)   cnt_d = cnt_q - WIDTH'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && zero) |=> zero);
endmodule

// File: rtl/asyw_write_seq.sv
module asyw_write_seq
    import asyw_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int WAIT_W      = 5,
    parameter int HOLD_W      = 3,
    parameter int RCV_CYC     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic              cfg_ack_en,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] mem_data_out,
    output logic              mem_data_oe
);
    localparam int RCV_W  = $clog2(RCV_CYC + 1);
    localparam int WH_W   = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;
    localparam int CNT_W  = (WH_W > RCV_W) ? WH_W : RCV_W;
    localparam logic [CNT_W-1:0] RCV_LOAD = CNT_W'(RCV_CYC - 1);
    localparam int GAP_W  = $clog2(RCV_CYC + 1) + 1;

    typedef struct packed {
        asyw_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [WAIT_W-1:0] wt;
        logic [HOLD_W-1:0] hd;
        logic              ack_en;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             ack_s;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_dec;
    logic             cnt_zero;
    logic             ack_ok;

    asyw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (mem_ack),
        .dout (ack_s)
    );

    asyw_cnt #(.WIDTH(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .dec     (cnt_dec),
        .zero    (cnt_zero)
    );

    assign ack_ok = !r_q.ack_en || ack_s;

    always_comb begin
        r_d      = r_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st     = ST_SETUP;
                    r_d.addr   = req_addr;
                    r_d.data   = req_data;
                    r_d.wt     = cfg_wait;
                    r_d.hd     = cfg_hold;
                    r_d.ack_en = cfg_ack_en;
                end
            end
            ST_SETUP: begin
                r_d.st   = ST_STROBE;
                cnt_load = 1'b1;
                cnt_val  = (r_q.wt == '0) ? '0 : CNT_W'(r_q.wt) - CNT_W'(1);
            end
            ST_STROBE: begin
                if (cnt_zero && ack_ok) begin
                    cnt_load = 1'b1;
                    if (r_q.hd == '0) begin
                        r_d.st  = ST_RECOVER;
                        cnt_val = RCV_LOAD;
                    end else begin
                        r_d.st  = ST_HOLD;
                        cnt_val = CNT_W'(r_q.hd) - CNT_W'(1);
                    end
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    r_d.st   = ST_RECOVER;
                    cnt_load = 1'b1;
                    cnt_val  = RCV_LOAD;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (cnt_zero) r_d.st = ST_IDLE;
                else          cnt_dec = 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready    = (r_q.st == ST_IDLE);
    assign mem_sel_n    = !(r_q.st == ST_SETUP || r_q.st == ST_STROBE || r_q.st == ST_HOLD);
    assign mem_wr_n     = (r_q.st != ST_STROBE);
    assign mem_data_oe  = (r_q.st == ST_STROBE || r_q.st == ST_HOLD);
    assign mem_addr     = r_q.addr;
    assign mem_data_out = r_q.data;

    // Cycles with the strobe high since it last was low (saturating), for the gap check.
    logic [GAP_W-1:0] gap_d, gap_q;
    always_comb begin
        gap_d = gap_q;
        if (!mem_wr_n)                        gap_d = '0;
        else if (gap_q < GAP_W'(RCV_CYC))     gap_d = gap_q + GAP_W'(1);
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= GAP_W'(RCV_CYC);
        else        gap_q <= gap_d;
    end

    a_r2_ready_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && mem_wr_n && !mem_data_oe));

    a_r3_select_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> !$past(mem_sel_n));

    a_r6_oe_under_select: assert property (@(posedge clk) disable iff (!rst_n)
        mem_data_oe |-> !mem_sel_n);

    a_r6_oe_rises_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_data_oe) |-> !mem_wr_n);

    a_r7_ack_stretches: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n && r_q.ack_en && !ack_s) |=> !mem_wr_n);

    a_r8_recovery_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> (gap_q >= GAP_W'(RCV_CYC)));

    a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && !$past(mem_sel_n)) |-> ($stable(mem_addr) && $stable(mem_data_out)));
endmodule

// File: tb/tb_asyw_write_seq.sv
module tb_asyw_write_seq;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [4:0]    cfg_wait = '0;
    logic [2:0]    cfg_hold = '0;
    logic          cfg_ack_en = 1'b0;
    logic          mem_ack = 1'b1;
    logic [AW-1:0] mem_addr;
    logic          mem_sel_n;
    logic          mem_wr_n;
    logic [DW-1:0] mem_data_out;
    logic          mem_data_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    asyw_write_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .cfg_wait(cfg_wait),
        .cfg_hold(cfg_hold), .cfg_ack_en(cfg_ack_en), .mem_ack(mem_ack),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_wr_n(mem_wr_n),
        .mem_data_out(mem_data_out), .mem_data_oe(mem_data_oe)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One write; ack_rise_k = 0 keeps mem_ack high, else ack is low until after sample k.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int w, input int h, input bit aen,
                            input int ack_rise_k, input string strobe_tag);
        int w1, ls, last;
        logic [3:0] exp_v, act_v;
        string tag;
        w1 = (w == 0) ? 1 : w;
        ls = (aen && ack_rise_k > 0 && ack_rise_k + 1 > w1) ? ack_rise_k + 1 : w1;
        last = ls + h + 4;
        if (ack_rise_k > 0) begin
            mem_ack = 1'b0;
            repeat (3) @(negedge clk);
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_data = d;
        cfg_wait = 5'(w); cfg_hold = 3'(h); cfg_ack_en = aen;
        @(posedge clk);
        for (int k = 1; k <= last; k++) begin
            @(negedge clk);
            exp_v[3] = (k == last);                         // ready
            exp_v[2] = !(k <= ls + 1 + h);                  // sel_n
            exp_v[1] = !(k >= 2 && k <= ls + 1);            // wr_n
            exp_v[0] = (k >= 2 && k <= ls + 1 + h);         // oe
            act_v = {req_ready, mem_sel_n, mem_wr_n, mem_data_oe};
            if (k == 1)               tag = "R3 setup";
            else if (k <= ls + 1)     tag = strobe_tag;
            else if (k <= ls + 1 + h) tag = "R5 hold / R6 oe";
            else if (k < last)        tag = "R8 recovery";
            else                      tag = "R2 ready return";
            chk(act_v == exp_v, tag, act_v, exp_v);
            if (!mem_sel_n)
                chk(mem_addr == a && mem_data_out == d, "R10 addr/data held",
                    {mem_addr, mem_data_out}, {a, d});
            if (k == 1) begin
                // R9 / R10: scramble inputs after acceptance
                req_valid = 1'b0; req_addr = ~a; req_data = ~d;
                cfg_wait = ~5'(w); cfg_hold = ~3'(h); cfg_ack_en = ~aen;
            end
            if (ack_rise_k > 0 && k == ack_rise_k) mem_ack = 1'b1;
        end
        mem_ack = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({req_ready, mem_sel_n, mem_wr_n, mem_data_oe} == 4'b1110, "R1 reset outputs",
            {req_ready, mem_sel_n, mem_wr_n, mem_data_oe}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        chk({req_ready, mem_sel_n, mem_wr_n, mem_data_oe} == 4'b1110, "R1 after release",
            {req_ready, mem_sel_n, mem_wr_n, mem_data_oe}, 4'b1110);

        // R4 / R5 sweep of wait and hold counts
        for (int w = 0; w <= 8; w++) begin
            for (int h = 0; h < 8; h++) begin
                int wv;
                wv = (w == 8) ? 31 : w;
                do_write(16'(16'h1000 + w * 8 + h), 16'(16'hA500 ^ (w * 37 + h)),
                         wv, h, 1'b0, 0, "R4 strobe");
            end
        end

        // R7: acknowledge stretches and is ignored when disabled
        do_write(16'h2001, 16'h3C3C, 2, 1, 1'b1, 6, "R7 ack stretch");
        do_write(16'h2002, 16'hC3C3, 10, 2, 1'b1, 3, "R7 ack early, wait rules");
        do_write(16'h2003, 16'h0F0F, 0, 0, 1'b1, 1, "R7 ack zero wait");
        do_write(16'h2004, 16'hF0F0, 3, 3, 1'b0, 12, "R7 ack ignored");
        do_write(16'h2005, 16'h1234, 1, 7, 1'b1, 9, "R7 ack long");
        // R9: captured config survives scrambling (scramble also in every run)
        do_write(16'h2006, 16'h5555, 4, 2, 1'b0, 0, "R9 captured config");
        do_write(16'h2007, 16'hAAAA, 31, 7, 1'b1, 0, "R9 captured max config");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule